// File: doc/BRIEF.md
# Reset Boot Vector Selector

This block decides, once per reset, where instruction fetch begins and whether the on-chip boot memory is switched on. It looks at an active-low boot-request pin and at a non-volatile bootloader jump fuse. From them it sets a boot-memory enable, an initial program counter and a flash-control status byte. It then makes the follow-on vector decision that a boot program would make. The execution target is one of three places: the user application at address zero, a user bootloader whose page comes from a software boot vector byte, or the factory bootloader at the base of the boot page.

The decision is captured on the first rising clock edge after reset is released and is then frozen until the next reset. A valid flag marks when the outputs hold a decision. A two-bit path code reports which branch was taken, so that later logic can tell a forced recovery from a fuse-requested boot.

Top module: `boot_vector_sel`

## Requirements
- R1: While `rst_n` is low, every output is zero: `sel_valid`, `boot_mem_en`, `init_pc`, `flash_stat`, `exec_addr` and `boot_path`.
- R2: The decision is loaded at the first rising edge of `clk` with `rst_n` high. `sel_valid` reads 0 before that edge and 1 after it.
- R3: If `boot_req_n` is 0, the result is `boot_mem_en`=1, `init_pc`=F000h, `flash_stat`=00h, `boot_path`=2 (factory by pin) and `exec_addr`=F000h, whatever the fuse and vector byte are. The pin takes precedence over the fuse.
- R4: If `boot_req_n` is 1 and `jump_fuse` is 1 (programmed), the result is `boot_mem_en`=1, `init_pc`=F000h and `flash_stat`=F0h.
- R5: If `boot_req_n` is 1 and `jump_fuse` is 0, the result is `boot_mem_en`=0, `init_pc`=0000h, `flash_stat`=F0h, `boot_path`=0 (standard application) and `exec_addr`=0000h, and the vector byte has no effect.
- R6: With the fuse path active and `sbv_byte` below F0h, `boot_path`=1 (user bootloader) and `exec_addr` = {`sbv_byte`, 00h}.
- R7: With the fuse path active and `sbv_byte` at F0h or above, `boot_path`=3 (factory by fuse, invalid vector) and `exec_addr`=F000h.
- R8: Once `sel_valid` is 1, every output holds its value through any change of `boot_req_n`, `jump_fuse` or `sbv_byte` until reset is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req_n | input | 1 | Boot-request pin, active low |
| jump_fuse | input | 1 | Bootloader jump fuse, 1 = programmed |
| sbv_byte | input | VEC_W (8) | Software boot vector, high byte of the user bootloader address |
| sel_valid | output | 1 | Decision captured |
| boot_mem_en | output | 1 | Boot memory enabled |
| init_pc | output | 2*VEC_W (16) | Initial program counter |
| flash_stat | output | 8 | Flash-control status value |
| exec_addr | output | 2*VEC_W (16) | Chosen execution target |
| boot_path | output | 2 | Path code: 0 application, 1 user bootloader, 2 factory by pin, 3 factory by fuse |

## Verification
The assertions assume that the pin, fuse and vector inputs hold steady from the release of reset through the first clock edge after it, and that a new reset is asserted before any fresh decision is expected. They do not depend on the inputs after that. The stimulus applies each combination while reset is held, releases reset between clock edges, and only then disturbs the inputs to probe the freeze. The stimulus covers all 1024 combinations of pin, fuse and vector byte, including both sides of the F0h bound.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    typedef enum logic [1:0] {
        PATH_APP       = 2'd0,
        PATH_USER      = 2'd1,
        PATH_FACT_PIN  = 2'd2,
        PATH_FACT_FUSE = 2'd3
    } boot_path_e;

    localparam int          STAT_W      = 8;
    localparam logic [7:0]  STAT_HWCOND = 8'h00;
    localparam logic [7:0]  STAT_NORMAL = 8'hF0;

endpackage

// File: rtl/boot_cond_stage.sv
module boot_cond_stage #(
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] BOOT_PAGE = 8'hF0,
    localparam int              ADDR_W    = 2 * VEC_W
) (
    input  logic                               req_n,
    input  logic                               fuse,
    output logic                               boot_en,
    output logic [ADDR_W-1:0]                  pc_init,
    output logic [boot_sel_pkg::STAT_W-1:0]    stat
);
    import boot_sel_pkg::*;

    localparam logic [ADDR_W-1:0] BOOT_BASE = {BOOT_PAGE, {VEC_W{1'b0}}};

    always_comb begin
        if (!req_n) begin
            // pin request wins over the fuse
            boot_en = 1'b1;
            pc_init = BOOT_BASE;
            stat    = STAT_HWCOND;
        end else if (fuse) begin
            boot_en = 1'b1;
            pc_init = BOOT_BASE;
            stat    = STAT_NORMAL;
        end else begin
            boot_en = 1'b0;
            pc_init = '0;
            stat    = STAT_NORMAL;
        end
    end
endmodule

// File: rtl/boot_vector_stage.sv
module boot_vector_stage #(
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] BOOT_PAGE = 8'hF0,
    localparam int              ADDR_W    = 2 * VEC_W
) (
    input  logic                            boot_en,
    input  logic [boot_sel_pkg::STAT_W-1:0] stat,
    input  logic [VEC_W-1:0]                vec,
    output boot_sel_pkg::boot_path_e        path,
    output logic [ADDR_W-1:0]               target
);
    import boot_sel_pkg::*;

    localparam logic [ADDR_W-1:0] BOOT_BASE = {BOOT_PAGE, {VEC_W{1'b0}}};

    logic vec_ok;
    assign vec_ok = (vec < BOOT_PAGE);

    always_comb begin
        if (!boot_en) begin
            path   = PATH_APP;
            target = '0;
        end else if (stat == STAT_HWCOND) begin
            path   = PATH_FACT_PIN;
            target = BOOT_BASE;
        end else if (vec_ok) begin
            path   = PATH_USER;
            target = {vec, {VEC_W{1'b0}}};
        end else begin
            path   = PATH_FACT_FUSE;
            target = BOOT_BASE;
        end
    end
endmodule

// File: rtl/boot_vector_sel.sv
module boot_vector_sel #(
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] BOOT_PAGE = 8'hF0,
    localparam int              ADDR_W    = 2 * VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_req_n,
    input  logic              jump_fuse,
    input  logic [VEC_W-1:0]  sbv_byte,
    output logic              sel_valid,
    output logic              boot_mem_en,
    output logic [ADDR_W-1:0] init_pc,
    output logic [7:0]        flash_stat,
    output logic [ADDR_W-1:0] exec_addr,
    output logic [1:0]        boot_path
);
    import boot_sel_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              boot_en;
        logic [ADDR_W-1:0] pc;
        logic [STAT_W-1:0] stat;
        logic [ADDR_W-1:0] target;
        boot_path_e        path;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic              c_boot_en;
    logic [ADDR_W-1:0] c_pc;
    logic [STAT_W-1:0] c_stat;
    boot_path_e        c_path;
    logic [ADDR_W-1:0] c_target;

    boot_cond_stage #(.VEC_W(VEC_W), .BOOT_PAGE(BOOT_PAGE)) u_cond (
        .req_n   (boot_req_n),
        .fuse    (jump_fuse),
        .boot_en (c_boot_en),
        .pc_init (c_pc),
        .stat    (c_stat)
    );

    // second stage works from the first stage's status, as a boot program would
    boot_vector_stage #(.VEC_W(VEC_W), .BOOT_PAGE(BOOT_PAGE)) u_vec (
        .boot_en (c_boot_en),
        .stat    (c_stat),
        .vec     (sbv_byte),
        .path    (c_path),
        .target  (c_target)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.valid) begin
            st_d.valid   = 1'b1;
            st_d.boot_en = c_boot_en;
            st_d.pc      = c_pc;
            st_d.stat    = c_stat;
            st_d.target  = c_target;
            st_d.path    = c_path;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, boot_en: 1'b0, pc: '0, stat: '0,
                      target: '0, path: PATH_APP};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_valid   = st_q.valid;
    assign boot_mem_en = st_q.boot_en;
    assign init_pc     = st_q.pc;
    assign flash_stat  = st_q.stat;
    assign exec_addr   = st_q.target;
    assign boot_path   = st_q.path;
endmodule

// File: rtl/boot_vector_sel_chk.sv
module boot_vector_sel_chk #(
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] BOOT_PAGE = 8'hF0,
    localparam int              ADDR_W    = 2 * VEC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_valid,
    input logic              boot_mem_en,
    input logic [ADDR_W-1:0] init_pc,
    input logic [7:0]        flash_stat,
    input logic [ADDR_W-1:0] exec_addr,
    input logic [1:0]        boot_path
);
    localparam logic [ADDR_W-1:0] BASE = {BOOT_PAGE, {VEC_W{1'b0}}};

    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_clear_r1: assert (!sel_valid && !boot_mem_en && boot_path == 2'd0
                                      && exec_addr == '0);
        end
    end

    p_valid_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> sel_valid);

    p_pin_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && boot_path == 2'd2) |->
            (boot_mem_en && init_pc == BASE && flash_stat == 8'h00 && exec_addr == BASE));

    p_fuse_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && boot_path[0]) |->
            (boot_mem_en && init_pc == BASE && flash_stat == 8'hF0));

    p_app_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !boot_mem_en) |->
            (boot_path == 2'd0 && init_pc == '0 && exec_addr == '0 && flash_stat == 8'hF0));

    p_user_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && boot_path == 2'd1) |->
            (exec_addr[VEC_W-1:0] == '0 && exec_addr[ADDR_W-1:VEC_W] < BOOT_PAGE));

    p_bad_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && boot_path == 2'd3) |-> (exec_addr == BASE));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> ($stable(exec_addr) && $stable(boot_path) && $stable(init_pc)
                       && $stable(flash_stat) && $stable(boot_mem_en)));
endmodule

bind boot_vector_sel boot_vector_sel_chk #(.VEC_W(VEC_W), .BOOT_PAGE(BOOT_PAGE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_valid   (sel_valid),
    .boot_mem_en (boot_mem_en),
    .init_pc     (init_pc),
    .flash_stat  (flash_stat),
    .exec_addr   (exec_addr),
    .boot_path   (boot_path)
);

// File: tb/sim_boot_vector_sel.sv
module sim_boot_vector_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_req_n = 1'b1;
    logic        jump_fuse = 1'b0;
    logic [7:0]  sbv_byte = 8'h00;
    logic        sel_valid;
    logic        boot_mem_en;
    logic [15:0] init_pc;
    logic [7:0]  flash_stat;
    logic [15:0] exec_addr;
    logic [1:0]  boot_path;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    boot_vector_sel u0 (
        .clk(clk), .rst_n(rst_n), .boot_req_n(boot_req_n), .jump_fuse(jump_fuse),
        .sbv_byte(sbv_byte), .sel_valid(sel_valid), .boot_mem_en(boot_mem_en),
        .init_pc(init_pc), .flash_stat(flash_stat), .exec_addr(exec_addr),
        .boot_path(boot_path)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < 2; f++) begin
                for (int v = 0; v < 256; v++) begin
                    logic        e_en;
                    logic [15:0] e_pc, e_tgt;
                    logic [7:0]  e_st;
                    logic [1:0]  e_path;
                    @(negedge clk);
                    rst_n      = 1'b0;
                    boot_req_n = p[0];
                    jump_fuse  = f[0];
                    sbv_byte   = v[7:0];
                    @(negedge clk);
                    // R1 reset state
                    chk("R1 valid", {31'd0, sel_valid}, 0);
                    chk("R1 outputs", {boot_mem_en, init_pc, boot_path, flash_stat[4:0]}, 0);
                    chk("R1 exec", {16'd0, exec_addr}, 0);
                    rst_n = 1'b1;
                    #1;
                    chk("R2 before edge", {31'd0, sel_valid}, 0);
                    // expected values from the requirements
                    if (p == 0) begin            // R3
                        e_en = 1; e_pc = 16'hF000; e_st = 8'h00; e_path = 2; e_tgt = 16'hF000;
                    end else if (f == 1) begin   // R4
                        e_en = 1; e_pc = 16'hF000; e_st = 8'hF0;
                        if (v < 'hF0) begin e_path = 1; e_tgt = {v[7:0], 8'h00}; end // R6
                        else begin e_path = 3; e_tgt = 16'hF000; end                 // R7
                    end else begin               // R5
                        e_en = 0; e_pc = 16'h0000; e_st = 8'hF0; e_path = 0; e_tgt = 16'h0000;
                    end
                    @(negedge clk);
                    chk("R2 valid", {31'd0, sel_valid}, 1);
                    chk(p == 0 ? "R3 en" : (f == 1 ? "R4 en" : "R5 en"), {31'd0, boot_mem_en}, {31'd0, e_en});
                    chk(p == 0 ? "R3 pc" : (f == 1 ? "R4 pc" : "R5 pc"), {16'd0, init_pc}, {16'd0, e_pc});
                    chk(p == 0 ? "R3 stat" : (f == 1 ? "R4 stat" : "R5 stat"), {24'd0, flash_stat}, {24'd0, e_st});
                    chk(p == 0 ? "R3 path" : (f == 0 ? "R5 path" : (v < 'hF0 ? "R6 path" : "R7 path")),
                        {30'd0, boot_path}, {30'd0, e_path});
                    chk(p == 0 ? "R3 exec" : (f == 0 ? "R5 exec" : (v < 'hF0 ? "R6 exec" : "R7 exec")),
                        {16'd0, exec_addr}, {16'd0, e_tgt});
                    // R8 disturb the inputs after the decision
                    boot_req_n = ~boot_req_n;
                    jump_fuse  = ~jump_fuse;
                    sbv_byte   = ~sbv_byte;
                    @(negedge clk);
                    @(negedge clk);
                    chk("R8 hold", {boot_mem_en, init_pc, boot_path, 13'd0},
                        {e_en, e_pc, e_path, 13'd0});
                    chk("R8 hold exec", {8'd0, flash_stat, exec_addr}, {8'd0, e_st, e_tgt});
                end
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule